// File: doc/BRIEF.md
# Strobe-Timed External Read Sequencer with Wait Stretching

This block runs one read access to an asynchronous external memory device. The access is timed by the read strobe. After a start request the block presents the address and drives the byte selects active. It then runs three phases: a setup phase with the strobe inactive, a pulse phase with the strobe active (low), and a hold phase with the strobe inactive again. A programmable down-counter times each phase. When the access finishes, a done flag is raised for exactly one cycle.

The device can ask for more time through an active-low wait pin. A chain of two flip-flops resynchronizes this pin before the sequencer uses it. Wait handling has two modes. In ready mode the strobe pulse may not end while wait is seen. In frozen mode every phase counter stops while wait is seen. The pulse counter looks at wait only up to the point where it reaches zero. So an assertion is honoured only when the programmed pulse is at least the device latency plus three cycles. With a shorter pulse the access drops into hold and the wait is missed.

A mode bit selects where the read data is captured. It is captured either on the last strobe cycle or on the last cycle of the whole access.

Top module: `rsq_read_seq`

## Requirements
- R1: A wait assertion that the device drives L cycles after the strobe falls (L=0 meaning the same cycle) stretches the pulse only when the effective pulse length P satisfies P >= L+3. With P <= L+2 the strobe rises after exactly P cycles.
- R2: With wait_mode_i equal to 2'b00 or 2'b01 the wait pin has no effect: the strobe stays low for exactly the effective pulse length.
- R3: In ready mode (wait_mode_i = 2'b11), when R1 is met, the strobe stays low for max(P, L+W+3) cycles, where W is the number of cycles the pin is held low. The hold phase is not affected by wait.
- R4: In frozen mode (wait_mode_i = 2'b10) the setup, pulse and hold counters stop during every cycle in which the synchronized wait is active. An honoured wait lengthens the pulse to P+W cycles. A missed wait that stays active into the hold phase lengthens the hold by the cycles it overlaps.
- R5: The strobe falls setup_len_i cycles after the clock edge that accepts the start request. A setup length of 0 makes the strobe fall on that same edge.
- R6: After the strobe rises the hold phase lasts hold_len_i cycles (0 skips it). done_o is then high for exactly one cycle, with the strobe and byte selects inactive.
- R7: With rd_mode_i = 1, rdata_o takes the value rdata_i had in the last strobe-low cycle. With rd_mode_i = 0, rdata_o takes the value rdata_i had in the last cycle of the access.
- R8: be_n_o is all zeros from the accepting edge until the access ends, and all ones when idle. addr_o does not change during an access.
- R9: A start request that arrives while an access is running is ignored. It starts no access and produces no done pulse.
- R10: After reset rd_n_o and be_n_o are all ones and done_o is low.
- R11: A programmed pulse length of 0 behaves as a length of 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Request to begin one read access (sampled when idle) |
| addr_i | input | AW | Address for the access |
| setup_len_i | input | CW | Setup phase length in cycles |
| pulse_len_i | input | CW | Strobe pulse length in cycles (0 acts as 1) |
| hold_len_i | input | CW | Hold phase length in cycles |
| wait_mode_i | input | 2 | 10 frozen, 11 ready, other values ignore wait |
| rd_mode_i | input | 1 | 1: capture at end of strobe, 0: capture at end of access |
| nwait_i | input | 1 | Raw asynchronous wait pin from the device, active low |
| rdata_i | input | DW | Read data bus from the device |
| addr_o | output | AW | Address presented to the device |
| rd_n_o | output | 1 | Read strobe, active low |
| be_n_o | output | BW | Byte selects, active low |
| rdata_o | output | DW | Captured read data |
| done_o | output | 1 | One-cycle pulse when the access has finished |

## Verification
The bench drives a device model that pulls the wait pin low a chosen number of cycles after the strobe falls and holds it for a chosen time. It runs that model against pulse lengths on both sides of the latency-plus-three boundary, in ready mode, frozen mode and the two ignoring encodings. Together these runs tell a honoured wait from a missed one, and a stretch of max(P, L+W+3) cycles from one of P+W. A missed wait in frozen mode shows up as a longer hold, which separates stopped counters from a simple pulse hold. Further accesses with zero setup, hold and pulse lengths, both capture modes, and a start request during a running access cover phase skipping, the capture point and request filtering.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SETUP  = 2'd1,
        PH_STROBE = 2'd2,
        PH_HOLD   = 2'd3
    } phase_e;

    localparam logic [1:0] WMODE_FROZEN = 2'b10;
    localparam logic [1:0] WMODE_READY  = 2'b11;

    // Upper bit of the mode field enables wait handling.
    function automatic logic wait_honoured(input logic [1:0] mode);
        return mode[1];
    endfunction

endpackage

// File: rtl/rsq_wait_sync.sv
module rsq_wait_sync #(
    parameter int   STAGES    = 2,
    parameter logic IDLE_LVL  = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic wait_act_o
);
    logic [STAGES-1:0] chain_d;
    logic [STAGES-1:0] chain_q;

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_comb chain_d[s] = pin_i;
            end else begin : g_next
                always_comb chain_d[s] = chain_q[s-1];
            end
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            chain_q <= {STAGES{IDLE_LVL}};
        end else begin
            chain_q <= chain_d;
        end
    end

    // Pin is active low: wait is active when the last stage reads low.
    assign wait_act_o = (chain_q[STAGES-1] != IDLE_LVL);
endmodule

// File: rtl/rsq_capture.sv
module rsq_capture #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          capture_i,
    input  logic [DW-1:0] data_i,
    output logic [DW-1:0] data_o
);
    logic [DW-1:0] data_d;
    logic [DW-1:0] data_q;

    always_comb begin
        data_d = data_q;
        if (capture_i) begin
            data_d = data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else begin
            data_q <= data_d;
        end
    end

    assign data_o = data_q;
endmodule

// File: rtl/rsq_seq_core.sv
module rsq_seq_core
    import rsq_pkg::*;
#(
    parameter int AW = 24,
    parameter int CW = 6,
    parameter int BW = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] addr_i,
    input  logic [CW-1:0] setup_len_i,
    input  logic [CW-1:0] pulse_len_i,
    input  logic [CW-1:0] hold_len_i,
    input  logic [1:0]    wait_mode_i,
    input  logic          rd_mode_i,
    input  logic          wait_act_i,
    output logic [AW-1:0] addr_o,
    output logic          rd_n_o,
    output logic [BW-1:0] be_n_o,
    output logic          done_o,
    output logic          capture_o
);
    localparam logic [CW-1:0] CNT_ONE  = CW'(1);
    localparam logic [CW-1:0] CNT_ZERO = '0;

    typedef struct packed {
        phase_e        phase;
        logic [CW-1:0] cnt;
        logic [AW-1:0] addr;
        logic [CW-1:0] plen;
        logic [CW-1:0] hlen;
        logic [1:0]    mode;
        logic          rdm;
        logic          strobe_n;
        logic [BW-1:0] be_n;
        logic          done;
    } seq_t;

    seq_t st_d;
    seq_t st_q;
    logic cap_d;

    // First counter value of a pulse: length 0 is treated as 1.
    function automatic logic [CW-1:0] pulse_first(input logic [CW-1:0] len);
        return (len == CNT_ZERO) ? CNT_ZERO : (len - CNT_ONE);
    endfunction

    logic frozen_now;
    logic stretch_req;

    always_comb begin
        frozen_now  = (st_q.mode == WMODE_FROZEN) && wait_act_i;
        stretch_req = wait_honoured(st_q.mode) && wait_act_i;
    end

    always_comb begin
        st_d       = st_q;
        st_d.done  = 1'b0;
        cap_d      = 1'b0;

        unique case (st_q.phase)
            PH_IDLE: begin
                if (start_i) begin
                    st_d.addr = addr_i;
                    st_d.plen = pulse_len_i;
                    st_d.hlen = hold_len_i;
                    st_d.mode = wait_mode_i;
                    st_d.rdm  = rd_mode_i;
                    st_d.be_n = '0;
                    if (setup_len_i != CNT_ZERO) begin
                        st_d.phase = PH_SETUP;
                        st_d.cnt   = setup_len_i - CNT_ONE;
                    end else begin
                        st_d.phase    = PH_STROBE;
                        st_d.cnt      = pulse_first(pulse_len_i);
                        st_d.strobe_n = 1'b0;
                    end
                end
            end

            PH_SETUP: begin
                if (!frozen_now) begin
                    if (st_q.cnt == CNT_ZERO) begin
                        st_d.phase    = PH_STROBE;
                        st_d.cnt      = pulse_first(st_q.plen);
                        st_d.strobe_n = 1'b0;
                    end else begin
                        st_d.cnt = st_q.cnt - CNT_ONE;
                    end
                end
            end

            PH_STROBE: begin
                if (st_q.cnt != CNT_ZERO) begin
                    if (!frozen_now) begin
                        st_d.cnt = st_q.cnt - CNT_ONE;
                    end
                end else if (!stretch_req) begin
                    st_d.strobe_n = 1'b1;
                    if (st_q.rdm) begin
                        cap_d = 1'b1;
                    end
                    if (st_q.hlen != CNT_ZERO) begin
                        st_d.phase = PH_HOLD;
                        st_d.cnt   = st_q.hlen - CNT_ONE;
                    end else begin
                        st_d.phase = PH_IDLE;
                        st_d.be_n  = '1;
                        st_d.done  = 1'b1;
                        if (!st_q.rdm) begin
                            cap_d = 1'b1;
                        end
                    end
                end
            end

            PH_HOLD: begin
                if (!frozen_now) begin
                    if (st_q.cnt == CNT_ZERO) begin
                        st_d.phase = PH_IDLE;
                        st_d.be_n  = '1;
                        st_d.done  = 1'b1;
                        if (!st_q.rdm) begin
                            cap_d = 1'b1;
                        end
                    end else begin
                        st_d.cnt = st_q.cnt - CNT_ONE;
                    end
                end
            end

            default: begin
                st_d.phase = PH_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.phase    <= PH_IDLE;
            st_q.cnt      <= '0;
            st_q.addr     <= '0;
            st_q.plen     <= '0;
            st_q.hlen     <= '0;
            st_q.mode     <= '0;
            st_q.rdm      <= 1'b0;
            st_q.strobe_n <= 1'b1;
            st_q.be_n     <= '1;
            st_q.done     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr_o    = st_q.addr;
    assign rd_n_o    = st_q.strobe_n;
    assign be_n_o    = st_q.be_n;
    assign done_o    = st_q.done;
    assign capture_o = cap_d;
endmodule

// File: rtl/rsq_read_seq.sv
module rsq_read_seq #(
    parameter int AW          = 24,
    parameter int DW          = 16,
    parameter int CW          = 6,
    parameter int SYNC_STAGES = 2,
    localparam int BW         = (DW + 7) / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic [AW-1:0] addr_i,
    input  logic [CW-1:0] setup_len_i,
    input  logic [CW-1:0] pulse_len_i,
    input  logic [CW-1:0] hold_len_i,
    input  logic [1:0]    wait_mode_i,
    input  logic          rd_mode_i,
    input  logic          nwait_i,
    input  logic [DW-1:0] rdata_i,
    output logic [AW-1:0] addr_o,
    output logic          rd_n_o,
    output logic [BW-1:0] be_n_o,
    output logic [DW-1:0] rdata_o,
    output logic          done_o
);
    logic wait_act;
    logic capture;

    rsq_wait_sync #(
        .STAGES   (SYNC_STAGES),
        .IDLE_LVL (1'b1)
    ) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .pin_i      (nwait_i),
        .wait_act_o (wait_act)
    );

    rsq_seq_core #(
        .AW (AW),
        .CW (CW),
        .BW (BW)
    ) u_core (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .addr_i      (addr_i),
        .setup_len_i (setup_len_i),
        .pulse_len_i (pulse_len_i),
        .hold_len_i  (hold_len_i),
        .wait_mode_i (wait_mode_i),
        .rd_mode_i   (rd_mode_i),
        .wait_act_i  (wait_act),
        .addr_o      (addr_o),
        .rd_n_o      (rd_n_o),
        .be_n_o      (be_n_o),
        .done_o      (done_o),
        .capture_o   (capture)
    );

    rsq_capture #(
        .DW (DW)
    ) u_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture_i (capture),
        .data_i    (rdata_i),
        .data_o    (rdata_o)
    );
endmodule

// File: rtl/rsq_read_seq_chk.sv
module rsq_read_seq_chk #(
    parameter int AW = 24,
    parameter int CW = 6,
    parameter int BW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic [CW-1:0] pulse_len_i,
    input logic [1:0]    wait_mode_i,
    input logic          nwait_i,
    input logic [AW-1:0] addr_o,
    input logic          rd_n_o,
    input logic [BW-1:0] be_n_o,
    input logic          done_o
);
    logic [15:0] low_run_q;
    logic [15:0] eff_pulse;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            low_run_q <= '0;
        end else if (!rd_n_o) begin
            low_run_q <= low_run_q + 16'd1;
        end else begin
            low_run_q <= '0;
        end
    end

    always_comb begin
        eff_pulse = (pulse_len_i == '0) ? 16'd1 : 16'(pulse_len_i);
    end

    // R1: a wait seen by the sequencer keeps the strobe low
    p_wait_stretch_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wait_mode_i[1] && !rd_n_o && !$past(nwait_i, 2)) |=> !rd_n_o);

    // R2: ignoring modes never stretch beyond the programmed pulse
    p_no_stretch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_n_o && !wait_mode_i[1]) |-> (low_run_q < eff_pulse));

    // R6: done is a single-cycle pulse
    p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R6: done only with strobe and byte selects inactive
    p_done_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (rd_n_o && (be_n_o == '1)));

    // R8: byte selects active while the strobe is low
    p_be_active_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_n_o |-> (be_n_o == '0));

    // R8: address stable while an access is running
    p_addr_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !be_n_o[0] |=> (be_n_o[0] || $stable(addr_o)));
endmodule

bind rsq_read_seq rsq_read_seq_chk #(
    .AW (AW),
    .CW (CW),
    .BW (BW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .pulse_len_i (pulse_len_i),
    .wait_mode_i (wait_mode_i),
    .nwait_i     (nwait_i),
    .addr_o      (addr_o),
    .rd_n_o      (rd_n_o),
    .be_n_o      (be_n_o),
    .done_o      (done_o)
);

// File: tb/sim_rsq_read_seq.sv
module sim_rsq_read_seq;
    localparam int AW = 24;
    localparam int DW = 16;
    localparam int CW = 6;
    localparam int BW = 2;
    localparam logic [DW-1:0] BUS_IDLE = 16'hA5C3;
    localparam logic [DW-1:0] BUS_KEY  = 16'h3C5A;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [CW-1:0] setup_len_i = '0;
    logic [CW-1:0] pulse_len_i = 6'd1;
    logic [CW-1:0] hold_len_i = '0;
    logic [1:0]    wait_mode_i = 2'b00;
    logic          rd_mode_i = 1'b1;
    logic          nwait_i = 1'b1;
    logic [DW-1:0] rdata_i;
    logic [AW-1:0] addr_o;
    logic          rd_n_o;
    logic [BW-1:0] be_n_o;
    logic [DW-1:0] rdata_o;
    logic          done_o;

    always #2 clk = ~clk;

    rsq_read_seq #(.AW(AW), .DW(DW), .CW(CW), .SYNC_STAGES(2)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .addr_i(addr_i),
        .setup_len_i(setup_len_i), .pulse_len_i(pulse_len_i),
        .hold_len_i(hold_len_i), .wait_mode_i(wait_mode_i),
        .rd_mode_i(rd_mode_i), .nwait_i(nwait_i), .rdata_i(rdata_i),
        .addr_o(addr_o), .rd_n_o(rd_n_o), .be_n_o(be_n_o),
        .rdata_o(rdata_o), .done_o(done_o)
    );

    // Device data: valid only while the strobe is low.
    assign rdata_i = rd_n_o ? BUS_IDLE : (addr_o[DW-1:0] ^ BUS_KEY);

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    typedef struct {
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        int            setup;
        int            width;
        int            tail;
        string         tag;
    } exp_t;

    exp_t sb[$];

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Device wait model
    bit dev_en  = 1'b0;
    int dev_lat = 0;
    int dev_w   = 0;

    initial begin
        forever begin
            @(negedge rd_n_o);
            if (dev_en) begin
                repeat (dev_lat) @(posedge clk);
                #1 nwait_i = 1'b0;
                repeat (dev_w) @(posedge clk);
                #1 nwait_i = 1'b1;
            end
        end
    end

    function automatic int calc_width(input int p, input logic [1:0] m,
                                      input bit dev, input int lat, input int w);
        int eff;
        eff = (p == 0) ? 1 : p;
        if (!dev || !m[1] || eff < lat + 3) return eff;
        if (m == 2'b11) return (eff > lat + w + 3) ? eff : (lat + w + 3);
        return eff + w;
    endfunction

    // Monitor
    int  mst = 0;
    int  scnt = 0, pw = 0, tcnt = 0;
    bit  be_bad = 1'b0;

    task automatic compare(input int tail_meas);
        exp_t e;
        if (sb.size() == 0) begin
            check(1'b0, "R9 unexpected done", 1, 0);
            return;
        end
        e = sb.pop_front();
        check(pw == e.width, {e.tag, " strobe width"}, pw, e.width);
        check(scnt == e.setup, "R5 setup cycles", scnt, e.setup);
        check(tail_meas == e.tail, {"R6 tail cycles (", e.tag, ")"}, tail_meas, e.tail);
        check(rdata_o == e.data, "R7 captured data", int'(rdata_o), int'(e.data));
        check(addr_o == e.addr, "R8 address", int'(addr_o), int'(e.addr));
        check(!be_bad, "R8 byte selects active", int'(be_bad), 0);
    endtask

    initial begin
        forever begin
            @(negedge clk);
            if (rst_n) begin
                case (mst)
                    0: begin
                        if (start_i) begin
                            mst = 1; scnt = 0; pw = 0; tcnt = 0; be_bad = 1'b0;
                        end
                    end
                    1: begin
                        if (be_n_o != '0) be_bad = 1'b1;
                        if (!rd_n_o) begin
                            mst = 2; pw = 1;
                        end else begin
                            scnt++;
                        end
                    end
                    2: begin
                        if (!rd_n_o) begin
                            if (be_n_o != '0) be_bad = 1'b1;
                            pw++;
                        end else if (done_o) begin
                            compare(0); mst = 0;
                        end else begin
                            if (be_n_o != '0) be_bad = 1'b1;
                            tcnt = 1; mst = 3;
                        end
                    end
                    default: begin
                        if (done_o) begin
                            compare(tcnt); mst = 0;
                        end else begin
                            if (be_n_o != '0) be_bad = 1'b1;
                            tcnt++;
                        end
                    end
                endcase
            end
        end
    end

    task automatic run_read(input logic [AW-1:0] a, input int s, input int p, input int h,
                            input logic [1:0] m, input logic rdm, input bit dev,
                            input int lat, input int w, input int exp_tail,
                            input string tag, input bit poke);
        exp_t e;
        e.addr  = a;
        e.setup = s;
        e.width = calc_width(p, m, dev, lat, w);
        e.tail  = exp_tail;
        e.data  = (rdm || h == 0) ? (a[DW-1:0] ^ BUS_KEY) : BUS_IDLE;
        e.tag   = tag;
        sb.push_back(e);
        @(posedge clk); #1;
        dev_en = dev; dev_lat = lat; dev_w = w;
        addr_i = a; setup_len_i = CW'(s); pulse_len_i = CW'(p);
        hold_len_i = CW'(h); wait_mode_i = m; rd_mode_i = rdm;
        start_i = 1'b1;
        @(posedge clk); #1;
        start_i = 1'b0;
        if (poke) begin
            wait (rd_n_o == 1'b0);
            @(posedge clk); #1;
            addr_i = ~a; start_i = 1'b1;
            @(posedge clk); #1;
            start_i = 1'b0;
        end
        wait (sb.size() == 0);
        repeat (lat + w + 8) @(posedge clk);
        #1 dev_en = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        // R10: reset state
        check(rd_n_o == 1'b1, "R10 strobe idle", int'(rd_n_o), 1);
        check(be_n_o == '1, "R10 byte selects idle", int'(be_n_o), 3);
        check(done_o == 1'b0, "R10 done low", int'(done_o), 0);

        // R5/R6/R7 basic access, no wait
        run_read(24'h000123, 2, 4, 3, 2'b00, 1'b1, 1'b0, 0, 0, 3, "R5 basic", 1'b0);
        // R2: wait pin ignored in mode 01
        run_read(24'h000456, 1, 4, 1, 2'b01, 1'b1, 1'b1, 0, 5, 1, "R2 ignored", 1'b0);
        // R3: ready mode stretch
        run_read(24'h000789, 1, 5, 2, 2'b11, 1'b1, 1'b1, 1, 4, 2, "R3 ready", 1'b0);
        // R1: boundary P = L+3 honoured (ready)
        run_read(24'h000ABC, 0, 5, 2, 2'b11, 1'b1, 1'b1, 2, 3, 2, "R1 boundary met", 1'b0);
        // R1: P = L+2 missed (ready), hold unaffected
        run_read(24'h000DEF, 0, 4, 2, 2'b11, 1'b1, 1'b1, 2, 3, 2, "R1 missed", 1'b0);
        // R4: frozen mode stretch P+W
        run_read(24'h001111, 1, 6, 2, 2'b10, 1'b1, 1'b1, 1, 3, 2, "R4 frozen", 1'b0);
        // R4/R1: frozen miss, hold frozen for overlap (hold 2 + 4)
        run_read(24'h002222, 1, 5, 2, 2'b10, 1'b1, 1'b1, 3, 4, 6, "R4 frozen miss", 1'b0);
        // R5/R6: zero setup and zero hold, capture at end of access
        run_read(24'h003333, 0, 3, 0, 2'b00, 1'b0, 1'b0, 0, 0, 0, "R6 no hold", 1'b0);
        // R7: capture at end of access with a hold phase
        run_read(24'h004444, 1, 2, 2, 2'b00, 1'b0, 1'b0, 0, 0, 2, "R7 end capture", 1'b0);
        // R11: pulse length 0 acts as 1
        run_read(24'h005555, 1, 0, 1, 2'b00, 1'b1, 1'b0, 0, 0, 1, "R11 zero pulse", 1'b0);
        // R9: start while busy ignored
        run_read(24'h006666, 1, 4, 2, 2'b00, 1'b1, 1'b0, 0, 0, 2, "R9 busy start", 1'b1);
        repeat (10) @(posedge clk);
        #1;
        check(sb.size() == 0, "R9 scoreboard drained", sb.size(), 0);
        check(rd_n_o == 1'b1, "R9 no extra access", int'(rd_n_o), 1);

        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            errors++;
            checks++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule